// File: doc/BRIEF.md
# Store queue with split-phase memory synchronization

This block is a per-processor store queue between an execution unit and a write-back cache port. The core hands stores to the queue and keeps running while the memory side stalls, for example on a cache miss. Stores leave the queue in arrival order through a valid/ready write port. Until a store has left the queue, other agents may briefly see stale values for its address.

Memory synchronization is split into two phases. A start command records, as a count, how many stores are waiting at that moment. It never stalls the core. A later wait request completes only once that many stores have been accepted by memory. Lock operations share the memory port and come in two kinds. A draining lock waits until the queue is empty before it goes out. A bypassing lock is sent ahead of older buffered stores, but only between store handshakes.

Top module: `stq_top`

## Requirements
- R1: A store is accepted (`stValid` and `stReady` both high at a clock edge) whenever the queue holds fewer than DEPTH entries. `stReady` is low while DEPTH entries are held.
- R2: Stores are presented on the memory port in the order they were accepted, with `memLock` low, and each store leaves the queue when `memReady` is high while it is presented.
- R3: Once `memValid` is high and `memReady` is low, the next cycle keeps `memValid` high with the same `memAddr`, `memData` and `memLock`.
- R4: A `syncStart` pulse loads the mark count with the queue occupancy at that edge. A store leaving at that same edge is not counted, and neither is a store entering at that edge. The pulse never lowers `stReady`.
- R5: `waitDone` is high exactly when `syncWait` is high and the mark count is zero. Each marked store that memory accepts lowers the count by one, so a wait issued with nothing outstanding completes in the same cycle.
- R6: A `syncStart` issued while an earlier mark is still nonzero replaces the count with the current occupancy.
- R7: A lock request with `lkDrain` high is presented (`memLock` high) only when the queue is empty. Its address and data appear on the memory port, and `lkReady` equals `memReady` while it is presented.
- R8: A lock request with `lkDrain` low is presented ahead of queued stores. It is never presented while a store is being presented and has not yet been accepted.
- R9: A synchronous active-high `rst` empties the queue, clears the mark count and releases any port ownership.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stValid | input | 1 | Store request from the core |
| stReady | output | 1 | Queue can take a store |
| stAddr | input | AW | Store address |
| stData | input | DW | Store data |
| syncStart | input | 1 | Pulse: mark all stores currently queued |
| syncWait | input | 1 | Core waits for marked stores |
| waitDone | output | 1 | Marked stores have drained |
| lkValid | input | 1 | Lock operation request, held until accepted |
| lkReady | output | 1 | Lock operation accepted by memory |
| lkDrain | input | 1 | 1 = drain queue before lock, 0 = bypass |
| lkAddr | input | AW | Lock address |
| lkData | input | DW | Lock write value |
| memValid | output | 1 | Memory write request |
| memReady | input | 1 | Memory accepts request |
| memAddr | output | AW | Memory write address |
| memData | output | DW | Memory write data |
| memLock | output | 1 | Request is a lock operation |

## Verification
The bench builds the block with DEPTH 4 and 16-bit addresses and data. The small depth means that phases with a rarely ready memory fill the queue often, so the full stall, marks taken from a full queue and draining locks blocked behind a full queue all occur many times. Narrow words keep the random values readable without affecting ordering checks. A reset in the middle of traffic, with marks, stalls and locks pending, is included.

// File: rtl/stq_pkg.sv
package stq_pkg;
  typedef struct packed {
    logic push;
    logic pop;
    logic selLock;
  } stqStrobes_t;
endpackage

// File: rtl/stq_datapath.sv
module stq_datapath
  import stq_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int DEPTH = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  stqStrobes_t   strobes,
  input  logic [AW-1:0] stAddr,
  input  logic [DW-1:0] stData,
  input  logic [AW-1:0] lkAddr,
  input  logic [DW-1:0] lkData,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memData
);
  logic [AW-1:0] addrQ [DEPTH];
  logic [DW-1:0] dataQ [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (strobes.push && wrPtr == PW'(e)) begin
        addrQ[e] <= stAddr;
        dataQ[e] <= stData;
      end
    end
  end

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobes.push) wrPtr <= nextPtr(wrPtr);
      if (strobes.pop)  rdPtr <= nextPtr(rdPtr);
      case ({strobes.push, strobes.pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign memAddr = strobes.selLock ? lkAddr : addrQ[rdPtr];
  assign memData = strobes.selLock ? lkData : dataQ[rdPtr];

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (rst)
    full |-> !strobes.push);
  p_no_underflow_r2: assert property (@(posedge clk) disable iff (rst)
    empty |-> !strobes.pop);
endmodule

// File: rtl/stq_control.sv
module stq_control
  import stq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stValid,
  input  logic          lkValid,
  input  logic          lkDrain,
  input  logic          syncStart,
  input  logic          syncWait,
  input  logic          memReady,
  input  logic [CW-1:0] count,
  input  logic          empty,
  input  logic          full,
  output stqStrobes_t   strobes,
  output logic          stReady,
  output logic          lkReady,
  output logic          memValid,
  output logic          memLock,
  output logic          waitDone
);
  logic holdStore, holdLock, selLock, pushNow, popNow;
  logic [CW-1:0] markCnt, markNext;

  // A transaction already on the port keeps it; otherwise a lock may go
  // (draining ones only on an empty queue), else the queue head.
  assign selLock  = holdLock | (~holdStore & lkValid & (~lkDrain | empty));
  assign memValid = selLock ? lkValid : ~empty;
  assign memLock  = selLock & memValid;
  assign stReady  = ~full;
  assign pushNow  = stValid & ~full;
  assign popNow   = memValid & memReady & ~selLock;
  assign lkReady  = memLock & memReady;
  assign strobes  = '{push: pushNow, pop: popNow, selLock: selLock};

  always_ff @(posedge clk) begin
    if (rst) begin
      holdStore <= 1'b0;
      holdLock  <= 1'b0;
    end else begin
      holdStore <= memValid & ~memReady & ~selLock;
      holdLock  <= memValid & ~memReady & selLock;
    end
  end

  always_comb begin
    if (syncStart)
      markNext = count - CW'(popNow);
    else if (popNow && markCnt != '0)
      markNext = markCnt - CW'(1);
    else
      markNext = markCnt;
  end

  always_ff @(posedge clk) begin
    if (rst) markCnt <= '0;
    else     markCnt <= markNext;
  end

  assign waitDone = syncWait & (markCnt == '0);

  p_drain_lock_r7: assert property (@(posedge clk) disable iff (rst)
    (memLock && lkDrain && !holdLock) |-> empty);
  p_mark_bound_r4: assert property (@(posedge clk) disable iff (rst)
    markCnt <= count);
endmodule

// File: rtl/stq_top.sv
module stq_top
  import stq_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stValid,
  output logic          stReady,
  input  logic [AW-1:0] stAddr,
  input  logic [DW-1:0] stData,
  input  logic          syncStart,
  input  logic          syncWait,
  output logic          waitDone,
  input  logic          lkValid,
  output logic          lkReady,
  input  logic          lkDrain,
  input  logic [AW-1:0] lkAddr,
  input  logic [DW-1:0] lkData,
  output logic          memValid,
  input  logic          memReady,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memData,
  output logic          memLock
);
  localparam int CW = $clog2(DEPTH + 1);

  stqStrobes_t   strobes;
  logic [CW-1:0] count;
  logic          empty, full;

  stq_control #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .stValid(stValid), .lkValid(lkValid),
    .lkDrain(lkDrain), .syncStart(syncStart), .syncWait(syncWait),
    .memReady(memReady), .count(count), .empty(empty), .full(full),
    .strobes(strobes), .stReady(stReady), .lkReady(lkReady),
    .memValid(memValid), .memLock(memLock), .waitDone(waitDone)
  );

  stq_datapath #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .stAddr(stAddr),
    .stData(stData), .lkAddr(lkAddr), .lkData(lkData), .count(count),
    .empty(empty), .full(full), .memAddr(memAddr), .memData(memData)
  );

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (memValid && !memReady) |=> (memValid && $stable(memAddr)
                                 && $stable(memData) && $stable(memLock)));
  p_no_midstore_bypass_r8: assert property (@(posedge clk) disable iff (rst)
    (memValid && !memReady && !memLock) |=> !memLock);
endmodule

// File: tb/stq_top_test.sv
module stq_top_test;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst;
  logic stValid, stReady, syncStart, syncWait, waitDone;
  logic lkValid, lkReady, lkDrain, memValid, memReady, memLock;
  logic [AW-1:0] stAddr, lkAddr, memAddr;
  logic [DW-1:0] stData, lkData, memData;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  stq_top #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .stValid(stValid), .stReady(stReady),
    .stAddr(stAddr), .stData(stData), .syncStart(syncStart),
    .syncWait(syncWait), .waitDone(waitDone), .lkValid(lkValid),
    .lkReady(lkReady), .lkDrain(lkDrain), .lkAddr(lkAddr), .lkData(lkData),
    .memValid(memValid), .memReady(memReady), .memAddr(memAddr),
    .memData(memData), .memLock(memLock)
  );

  // Reference state
  logic [AW+DW-1:0] q[$];
  int  markCnt = 0;
  bit  holdS = 0, holdL = 0, restarted = 0, lockAccPrev = 0;
  bit  eSelL, eValid;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareNow();
    int qs = q.size();
    string tag;
    eSelL  = holdL || (!holdS && lkValid && (!lkDrain || qs == 0));
    eValid = eSelL ? lkValid : (qs != 0);
    chk("R1 stReady", stReady, qs < DEPTH);
    chk("R3 memValid", memValid, eValid);
    chk("R7 lkReady", lkReady, eSelL && lkValid && memReady);
    tag = (markCnt == 0) ? "R5 waitDone" : (restarted ? "R6 waitDone" : "R4 waitDone");
    chk(tag, waitDone, syncWait && markCnt == 0);
    if (eValid) begin
      if (eSelL) begin
        tag = lkDrain ? "R7 lock" : "R8 lock";
        chk(tag, memLock, 1'b1);
        chk(tag, memAddr, lkAddr);
        chk(tag, memData, lkData);
      end else begin
        chk("R2 memLock", memLock, 1'b0);
        chk("R2 memAddr", memAddr, q[0][AW+DW-1:DW]);
        chk("R2 memData", memData, q[0][DW-1:0]);
      end
    end
  endtask

  task automatic updateModel();
    bit pop, lockAcc, nS, nL;
    int qs = q.size();
    pop     = eValid && memReady && !eSelL;
    lockAcc = eValid && memReady && eSelL;
    nS = eValid && !memReady && !eSelL;
    nL = eValid && !memReady && eSelL;
    lockAccPrev = lockAcc;
    if (rst) begin
      q.delete();
      markCnt = 0; holdS = 0; holdL = 0; restarted = 0;
      return;
    end
    holdS = nS; holdL = nL;
    if (syncStart) begin
      restarted = (markCnt != 0);
      markCnt = qs - int'(pop);
    end else if (pop && markCnt > 0) markCnt--;
    if (markCnt == 0) restarted = 0;
    if (pop) void'(q.pop_front());
    if (stValid && qs < DEPTH) q.push_back({stAddr, stData});
  endtask

  task automatic cycle(int pSt, int pRdy, int pLk, bit doRst);
    @(negedge clk);
    rst = doRst;
    if (lockAccPrev) lkValid = 1'b0;
    stValid   = ($urandom % 100) < pSt;
    stAddr    = AW'($urandom);
    stData    = DW'($urandom);
    syncStart = ($urandom % 10) == 0;
    syncWait  = $urandom % 2;
    memReady  = doRst ? 1'b0 : (($urandom % 100) < pRdy);
    if (!lkValid && (($urandom % 100) < pLk)) begin
      lkValid = 1'b1;
      lkDrain = $urandom % 2;
      lkAddr  = AW'($urandom);
      lkData  = DW'($urandom);
    end
    #5;
    compareNow();
    @(posedge clk);
    updateModel();
  endtask

  initial begin
    rst = 1'b1; stValid = 0; syncStart = 0; syncWait = 1; lkValid = 0;
    lkDrain = 0; memReady = 0; stAddr = '0; stData = '0; lkAddr = '0; lkData = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #5;
    // R9: reset state is empty with no mark
    chk("R9 stReady", stReady, 1'b1);
    chk("R9 memValid", memValid, 1'b0);
    chk("R9 waitDone", waitDone, 1'b1);
    @(posedge clk);
    for (int i = 0; i < 1200; i++) cycle(80, 20, 4, 0);   // fills often
    for (int i = 0; i < 1200; i++) cycle(50, 75, 6, 0);
    for (int i = 0; i < 600; i++)  cycle(70, 50, 8, 0);
    cycle(70, 50, 8, 1);                                   // R9 mid-run
    @(negedge clk);
    rst = 1'b0; syncWait = 1'b1; stValid = 1'b0; syncStart = 1'b0;
    if (lockAccPrev) lkValid = 1'b0;
    lkValid = 1'b0; memReady = 1'b0;
    #5;
    chk("R9 stReady after reset", stReady, 1'b1);
    chk("R9 memValid after reset", memValid, 1'b0);
    chk("R9 waitDone after reset", waitDone, 1'b1);
    compareNow();
    @(posedge clk);
    updateModel();
    for (int i = 0; i < 1000; i++) cycle(60, 40, 5, 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule